// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides, sample by sample, whether a capture channel has reached the event it is waiting for. Each valid sample word is tested against a masked pattern, an inclusive unsigned window, an arm line from a neighbouring capture channel and the terminal condition of a 16-bit event counter. A small programmable state machine then acts on the result. Every state holds two clauses. A clause picks one event, may invert it, and names one action: stay, jump to a target state, fire the trigger, count up or clear the counter. Both clauses of the current state are tested in the same cycle, and the lower-numbered true clause wins.

The block has two outputs toward the capture buffer. One is a one-cycle trigger pulse. The other is a store-qualify strobe, so that only chosen samples are written. When the trigger fires, the block also raises a level toward a neighbouring channel so that the neighbour can begin its own search. After it fires, the sequencer ignores samples until software pulses the start input again. All settings are loaded through a plain write-only register port.

Top module: `trig_seq`

## Requirements
- R1: While reset is held and after it is released, trig_out, qual_out, peer_arm_out and seq_active are 0. Samples have no effect until arm_start has been pulsed.
- R2: Event code 1 (pattern) is true when every bit set in the mask register (address 1) has the same value in the sample as in the pattern register (address 0). Bits whose mask bit is 0 are ignored.
- R3: Event code 2 (window) is true when lower (address 2) <= sample <= upper (address 3), compared unsigned, with both bounds included.
- R4: Event code 3 follows peer_arm_in in the sample's cycle. peer_arm_out goes to 1 in the same cycle as the trigger pulse and stays at 1 until the cycle after the next arm_start.
- R5: The counter is CNT_W (16) bits wide and resets to 0 on arm_start. Action 3 increments it only while it is below the limit (address 4), so it saturates at the limit. Action 4 clears it. Event code 4 is true while counter >= limit.
- R6: arm_start puts the sequencer in state 0. Action 1 moves it to the clause's target state. A target of NUM_STATES or above leaves the state unchanged.
- R7: When both clauses of the current state are true, only the action of clause 0 is carried out.
- R8: The clause's invert bit complements the selected event. Event code 0 is always false, code 5 is always true, and codes 6 and 7 are false.
- R9: Action 2 gives trig_out = 1 for exactly the one cycle after the firing sample, and seq_active drops in that same cycle. Samples have no effect until the next arm_start.
- R10: qual_out is 1 in the cycle after a sample that was evaluated while active, if the current state's bit in the store register (address 5, bit n for state n) is set or that sample fired the trigger. Otherwise qual_out is 0.
- R11: A clause word is written at address 8 + 2*state + clause. Its bits are: event [2:0], invert [3], action [6:4], target [10:7]. Action codes 0 and 5 to 7 mean stay. A write takes effect for samples in the following cycles, including while the sequencer is running.
- R12: A cycle with smp_valid = 0 changes neither the state nor the counter and does not produce a trigger or a qualify strobe. arm_start takes precedence over a sample presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (4) | Register address |
| cfg_wdata | input | DATA_W (16) | Register write data |
| arm_start | input | 1 | Start or rearm: state 0, counter cleared, active |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | DATA_W (16) | Sample word |
| peer_arm_in | input | 1 | Arm event from a neighbouring channel |
| trig_out | output | 1 | One-cycle trigger pulse |
| qual_out | output | 1 | Store strobe for the capture buffer |
| peer_arm_out | output | 1 | Arm level toward a neighbouring channel |
| seq_active | output | 1 | Sequencer is searching |

## Verification
The checker assumes that arm_start, smp_valid and peer_arm_in are synchronous single-bit levels that are defined at every clock edge after reset. It also assumes that the counter changes only by a step of one or by a clear, because the limit is the only value that can stop an increment. The bench drives every input just after the falling edge, so each one holds steady across the rising edge. It varies the configuration freely, including while the sequencer runs, because R11 allows such writes. Random stimulus keeps sample values, bounds and limits in a small range so that the pattern, window and counter events all fire often.

// File: rtl/trig_seq_pkg.sv
`timescale 1ns/1ps
package trig_seq_pkg;
   localparam int TGT_W = 4;

   typedef enum logic [2:0] {
      EV_NEVER  = 3'd0,
      EV_PAT    = 3'd1,
      EV_WIN    = 3'd2,
      EV_PEER   = 3'd3,
      EV_CNT    = 3'd4,
      EV_ALWAYS = 3'd5
   } ev_e;

   typedef enum logic [2:0] {
      ACT_STAY = 3'd0,
      ACT_GOTO = 3'd1,
      ACT_FIRE = 3'd2,
      ACT_INC  = 3'd3,
      ACT_CLR  = 3'd4
   } act_e;

   typedef struct packed {
      logic [TGT_W-1:0] tgt;
      act_e             act;
      logic             inv;
      ev_e              ev;
   } clause_t;

   localparam int CLAUSE_W = $bits(clause_t);

   localparam int A_PAT_VAL  = 0;
   localparam int A_PAT_MASK = 1;
   localparam int A_WIN_LO   = 2;
   localparam int A_WIN_HI   = 3;
   localparam int A_CNT_LIM  = 4;
   localparam int A_STORE    = 5;
   localparam int A_CL_BASE  = 8;
endpackage

// File: rtl/trig_seq_cfg.sv
`timescale 1ns/1ps
module trig_seq_cfg
   import trig_seq_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int NUM_STATES  = 4,
   parameter int NUM_CLAUSES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         pat_val,
   output logic [DATA_W-1:0]         pat_mask,
   output logic [DATA_W-1:0]         win_lo,
   output logic [DATA_W-1:0]         win_hi,
   output logic [CNT_W-1:0]          cnt_lim,
   output logic [NUM_STATES-1:0]     st_store,
   output clause_t [NUM_STATES-1:0][NUM_CLAUSES-1:0] clauses
);
   localparam int NSLOT = NUM_STATES * NUM_CLAUSES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_val  <= '0;
         pat_mask <= '0;
         win_lo   <= '0;
         win_hi   <= '0;
         cnt_lim  <= '0;
         st_store <= '0;
      end else if (we) begin
         if (addr == ADDR_W'(A_PAT_VAL))  pat_val  <= wdata;
         if (addr == ADDR_W'(A_PAT_MASK)) pat_mask <= wdata;
         if (addr == ADDR_W'(A_WIN_LO))   win_lo   <= wdata;
         if (addr == ADDR_W'(A_WIN_HI))   win_hi   <= wdata;
         if (addr == ADDR_W'(A_CNT_LIM))  cnt_lim  <= wdata[CNT_W-1:0];
         if (addr == ADDR_W'(A_STORE))    st_store <= wdata[NUM_STATES-1:0];
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            clauses[s / NUM_CLAUSES][s % NUM_CLAUSES] <= '0;
         else if (we && addr == ADDR_W'(A_CL_BASE + s))
            clauses[s / NUM_CLAUSES][s % NUM_CLAUSES] <= clause_t'(wdata[CLAUSE_W-1:0]);
      end
   end
endmodule

// File: rtl/trig_seq_match.sv
`timescale 1ns/1ps
module trig_seq_match #(
   parameter int DATA_W  = 16,
   parameter bit HAS_WIN = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] pat_val,
   input  logic [DATA_W-1:0] pat_mask,
   input  logic [DATA_W-1:0] win_lo,
   input  logic [DATA_W-1:0] win_hi,
   output logic              pat_hit,
   output logic              win_hit
);
   logic [DATA_W-1:0] diff;
   assign diff    = (data ^ pat_val) & pat_mask;
   assign pat_hit = (diff == '0);

   if (HAS_WIN) begin : g_win
      logic above_lo, below_hi;
      assign above_lo = (data >= win_lo);
      assign below_hi = (data <= win_hi);
      assign win_hit  = above_lo & below_hi;
   end else begin : g_nowin
      logic unused_win;
      assign unused_win = ^{win_lo, win_hi};
      assign win_hit    = 1'b0;
   end
endmodule

// File: rtl/trig_seq_core.sv
`timescale 1ns/1ps
module trig_seq_core
   import trig_seq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_STATES  = 4,
   parameter int NUM_CLAUSES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arm_start,
   input  logic                  smp_valid,
   input  logic                  pat_hit,
   input  logic                  win_hit,
   input  logic                  peer_in,
   input  logic [CNT_W-1:0]      cnt_lim,
   input  logic [NUM_STATES-1:0] st_store,
   input  clause_t [NUM_STATES-1:0][NUM_CLAUSES-1:0] clauses,
   output logic                  trig_o,
   output logic                  qual_o,
   output logic                  peer_o,
   output logic                  active_o
);
   localparam int SW = $clog2(NUM_STATES);
   localparam logic [TGT_W:0] NS_LIM = (TGT_W + 1)'(NUM_STATES);

   logic [SW-1:0]          state_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   run_q, trig_q, qual_q, peer_q;
   logic                   cnt_hit;
   logic [7:0]             evv;
   logic [NUM_CLAUSES-1:0] hit;
   act_e                   cl_act [NUM_CLAUSES];
   logic [TGT_W-1:0]       cl_tgt [NUM_CLAUSES];
   logic                   win_any;
   act_e                   win_act;
   logic [TGT_W-1:0]       win_tgt;

   assign cnt_hit = (cnt_q >= cnt_lim);
   assign evv = {1'b0, 1'b0, 1'b1, cnt_hit, peer_in, win_hit, pat_hit, 1'b0};

   for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_cl
      clause_t cl;
      assign cl        = clauses[state_q][c];
      assign hit[c]    = evv[cl.ev] ^ cl.inv;
      assign cl_act[c] = cl.act;
      assign cl_tgt[c] = cl.tgt;
   end

   always_comb begin
      win_any = 1'b0;
      win_act = ACT_STAY;
      win_tgt = '0;
      for (int c = 0; c < NUM_CLAUSES; c++) begin
         if (hit[c] && !win_any) begin
            win_any = 1'b1;
            win_act = cl_act[c];
            win_tgt = cl_tgt[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         trig_q  <= 1'b0;
         qual_q  <= 1'b0;
         peer_q  <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         qual_q <= 1'b0;
         if (arm_start) begin
            run_q   <= 1'b1;
            state_q <= '0;
            cnt_q   <= '0;
            peer_q  <= 1'b0;
         end else if (run_q && smp_valid) begin
            qual_q <= st_store[state_q] | (win_act == ACT_FIRE);
            case (win_act)
               ACT_GOTO: if ({1'b0, win_tgt} < NS_LIM) state_q <= win_tgt[SW-1:0];
               ACT_FIRE: begin
                  trig_q <= 1'b1;
                  run_q  <= 1'b0;
                  peer_q <= 1'b1;
               end
               ACT_INC:  if (!cnt_hit) cnt_q <= cnt_q + 1'b1;
               ACT_CLR:  cnt_q <= '0;
               default:  ;
            endcase
         end
      end
   end

   assign trig_o   = trig_q;
   assign qual_o   = qual_q;
   assign peer_o   = peer_q;
   assign active_o = run_q;
endmodule

// File: rtl/trig_seq.sv
`timescale 1ns/1ps
module trig_seq
   import trig_seq_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int NUM_STATES  = 4,
   parameter int NUM_CLAUSES = 2,
   parameter int ADDR_W      = 4,
   parameter bit HAS_WIN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              arm_start,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              peer_arm_in,
   output logic              trig_out,
   output logic              qual_out,
   output logic              peer_arm_out,
   output logic              seq_active
);
   localparam int NSLOT = NUM_STATES * NUM_CLAUSES;

   if (NUM_STATES < 2 || NUM_STATES > (1 << TGT_W) ||
       (NUM_STATES & (NUM_STATES - 1)) != 0) begin : g_bad_states
      initial $fatal(1, "NUM_STATES must be a power of two within the target field");
   end
   if (NUM_CLAUSES < 1) begin : g_bad_clauses
      initial $fatal(1, "NUM_CLAUSES must be at least one");
   end
   if (DATA_W < CLAUSE_W || DATA_W < CNT_W || DATA_W < NUM_STATES) begin : g_bad_width
      initial $fatal(1, "DATA_W too narrow for configuration words");
   end
   if ((A_CL_BASE + NSLOT) > (1 << ADDR_W)) begin : g_bad_addr
      initial $fatal(1, "ADDR_W too small for the clause slots");
   end

   logic [DATA_W-1:0]     pat_val, pat_mask, win_lo, win_hi;
   logic [CNT_W-1:0]      cnt_lim;
   logic [NUM_STATES-1:0] st_store;
   clause_t [NUM_STATES-1:0][NUM_CLAUSES-1:0] clauses;
   logic                  pat_hit, win_hit;

   trig_seq_cfg #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_STATES(NUM_STATES),
      .NUM_CLAUSES(NUM_CLAUSES), .ADDR_W(ADDR_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .pat_val(pat_val), .pat_mask(pat_mask), .win_lo(win_lo), .win_hi(win_hi),
      .cnt_lim(cnt_lim), .st_store(st_store), .clauses(clauses)
   );

   trig_seq_match #(.DATA_W(DATA_W), .HAS_WIN(HAS_WIN)) u_match (
      .data(smp_data), .pat_val(pat_val), .pat_mask(pat_mask),
      .win_lo(win_lo), .win_hi(win_hi), .pat_hit(pat_hit), .win_hit(win_hit)
   );

   trig_seq_core #(
      .CNT_W(CNT_W), .NUM_STATES(NUM_STATES), .NUM_CLAUSES(NUM_CLAUSES)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .arm_start(arm_start), .smp_valid(smp_valid),
      .pat_hit(pat_hit), .win_hit(win_hit), .peer_in(peer_arm_in),
      .cnt_lim(cnt_lim), .st_store(st_store), .clauses(clauses),
      .trig_o(trig_out), .qual_o(qual_out), .peer_o(peer_arm_out),
      .active_o(seq_active)
   );
endmodule

// File: rtl/trig_seq_chk.sv
`timescale 1ns/1ps
module trig_seq_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_start,
   input logic             smp_valid,
   input logic             trig_out,
   input logic             qual_out,
   input logic             peer_arm_out,
   input logic             seq_active,
   input logic [CNT_W-1:0] cnt_val
);
   // R9: the trigger lasts a single cycle
   p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out);

   // R9: firing leaves the sequencer inactive
   p_trig_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> !seq_active);

   // R9 / R12: a trigger always follows a presented sample
   p_trig_from_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> $past(smp_valid) && !$past(arm_start));

   // R9: only arm_start wakes the sequencer
   p_stay_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_active && !arm_start |=> !seq_active);

   // R4: the outbound arm rises together with the trigger
   p_peer_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(peer_arm_out) |-> trig_out);

   // R4: the outbound arm holds until a rearm
   p_peer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      peer_arm_out && !arm_start |=> peer_arm_out);

   // R10: a store strobe needs an evaluated sample
   p_qual_from_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
      qual_out |-> $past(smp_valid) && $past(seq_active) && !$past(arm_start));

   // R5: the counter only steps by one or returns to zero
   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_val != $past(cnt_val) |-> (cnt_val == '0) || (cnt_val == $past(cnt_val) + 1'b1));
endmodule

bind trig_seq trig_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm_start(arm_start), .smp_valid(smp_valid),
   .trig_out(trig_out), .qual_out(qual_out), .peer_arm_out(peer_arm_out),
   .seq_active(seq_active), .cnt_val(u_core.cnt_q)
);

// File: tb/trig_seq_test.sv
`timescale 1ns/1ps
module trig_seq_test;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int NSTATE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          arm_start = 1'b0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          peer_arm_in = 1'b0;
   logic          trig_out, qual_out, peer_arm_out, seq_active;

   trig_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .arm_start(arm_start), .smp_valid(smp_valid),
      .smp_data(smp_data), .peer_arm_in(peer_arm_in), .trig_out(trig_out),
      .qual_out(qual_out), .peer_arm_out(peer_arm_out), .seq_active(seq_active)
   );

   always #2.5 clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    dut_trigs = 0;
   bit    finished = 1'b0;
   string cur_req = "R1 reset";

   // behavioural reference
   int m_cfg [16];
   int m_st, m_cnt;
   bit m_run, m_trig, m_qual, m_peer;

   function automatic bit ref_event(int code, int d);
      int lim;
      lim = m_cfg[4];
      case (code)
         1: return ((d ^ m_cfg[0]) & m_cfg[1]) == 0;
         2: return (d >= m_cfg[2]) && (d <= m_cfg[3]);
         3: return peer_arm_in;
         4: return m_cnt >= lim;
         5: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_cfg[i]) m_cfg[i] = 0;
         m_st = 0; m_cnt = 0; m_run = 0; m_trig = 0; m_qual = 0; m_peer = 0;
      end else begin
         bit t, q, found;
         int act, tgt;
         t = 0; q = 0; found = 0; act = 0; tgt = 0;
         if (arm_start) begin
            m_run = 1; m_st = 0; m_cnt = 0; m_peer = 0;
         end else if (m_run && smp_valid) begin
            for (int c = 0; c < 2; c++) begin
               int w;
               bit e;
               w = m_cfg[8 + 2 * m_st + c];
               e = ref_event(w % 8, int'(smp_data));
               if ((w / 8) % 2 == 1) e = !e;
               if (e && !found) begin
                  found = 1; act = (w / 16) % 8; tgt = (w / 128) % 16;
               end
            end
            q = ((m_cfg[5] >> m_st) & 1) == 1;
            case (act)
               1: if (tgt < NSTATE) m_st = tgt;
               2: begin t = 1; q = 1; m_run = 0; m_peer = 1; end
               3: if (m_cnt < m_cfg[4]) m_cnt = m_cnt + 1;
               4: m_cnt = 0;
               default: ;
            endcase
         end
         m_trig = t;
         m_qual = q;
         if (cfg_we) m_cfg[int'(cfg_addr)] = int'(cfg_wdata);
      end
   end

   task automatic cmp(string what, bit act, bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         cmp("trig_out", trig_out, m_trig);
         cmp("qual_out", qual_out, m_qual);
         cmp("peer_arm_out", peer_arm_out, m_peer);
         cmp("seq_active", seq_active, m_run);
         if (trig_out === 1'b1) dut_trigs++;
      end
   end

   task automatic check_int(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int cl(int ev, int inv, int act, int tgt);
      return ev + inv * 8 + act * 16 + tgt * 128;
   endfunction

   task automatic wr(int a, int d);
      cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = DW'(d);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic smp(int d, bit v = 1, bit p = 0);
      smp_valid = v; smp_data = DW'(d); peer_arm_in = p;
      @(negedge clk);
      smp_valid = 0; peer_arm_in = 0;
   endtask

   task automatic start();
      arm_start = 1;
      @(negedge clk);
      arm_start = 0;
   endtask

   task automatic expect_trigs(string req, int exp);
      @(negedge clk);
      #1;
      check_int(req, dut_trigs, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check_int("R1 trig_out in reset", int'(trig_out), 0);
      check_int("R1 seq_active in reset", int'(seq_active), 0);
      rst_n = 1;
      @(negedge clk);
      check_int("R1 peer_arm_out after reset", int'(peer_arm_out), 0);
      wr(8, cl(5, 0, 2, 0));
      smp(16'h0001); smp(16'h0002);
      expect_trigs("R1 no trigger before arm", 0);

      cur_req = "R2 pattern";
      wr(0, 16'h1234); wr(1, 16'hFF00); wr(8, cl(1, 0, 2, 0));
      start();
      smp(16'h3434); smp(16'h12AB);
      cur_req = "R9 inactive after fire";
      smp(16'h1200); smp(16'h12FF);
      expect_trigs("R2 masked pattern fires once", 1);
      check_int("R9 seq_active low after fire", int'(seq_active), 0);
      check_int("R4 peer_arm_out held", int'(peer_arm_out), 1);

      cur_req = "R3 window";
      wr(2, 16'h0100); wr(3, 16'h0200); wr(8, cl(2, 0, 2, 0));
      start();
      smp(16'h00FF); smp(16'h0201); smp(16'hFFFF);
      expect_trigs("R3 outside window", 1);
      smp(16'h0200);
      expect_trigs("R3 upper bound inclusive", 2);
      start();
      smp(16'h0100);
      expect_trigs("R3 lower bound inclusive", 3);

      cur_req = "R6 R8 R10 R12 sequence";
      wr(0, 16'hAAAA); wr(1, 16'hFFFF);
      wr(8, cl(1, 0, 1, 1)); wr(9, cl(2, 0, 1, 9));
      wr(10, cl(3, 0, 2, 0)); wr(11, cl(2, 1, 1, 0));
      wr(5, 2);
      start();
      smp(16'h0150); smp(16'hAAAA); smp(16'h0180); smp(16'h5000);
      smp(16'hAAAA); smp(16'h0180, 0, 1);
      expect_trigs("R12 idle sample ignored", 3);
      cur_req = "R4 peer event";
      smp(16'h0180, 1, 1);
      expect_trigs("R4 peer event fires", 4);

      cur_req = "R5 counter";
      wr(4, 3); wr(5, 0); wr(1, 0);
      wr(8, cl(4, 0, 2, 0)); wr(9, cl(1, 0, 3, 0));
      start();
      smp(1); smp(2); smp(3);
      expect_trigs("R5 limit not reached", 4);
      smp(4);
      expect_trigs("R5 terminal count fires", 5);
      wr(4, 2); wr(8, cl(1, 0, 3, 0)); wr(9, 0);
      start();
      for (int i = 0; i < 5; i++) smp(i);
      wr(4, 3); wr(8, cl(4, 0, 2, 0)); wr(9, cl(1, 0, 3, 0));
      smp(7);
      expect_trigs("R5 saturated below new limit", 5);
      smp(8);
      expect_trigs("R5 fires after one more step", 6);

      cur_req = "R7 priority";
      wr(4, 2); wr(8, cl(3, 0, 4, 0)); wr(9, cl(5, 0, 3, 0));
      start();
      smp(1); smp(2); smp(3, 1, 1); smp(4);
      wr(8, cl(4, 0, 2, 0));
      smp(5);
      expect_trigs("R7 clause 0 clear won", 6);
      smp(6);
      expect_trigs("R7 count resumed", 7);

      cur_req = "R12 start beats sample";
      wr(8, cl(5, 0, 2, 0));
      arm_start = 1; smp_valid = 1; smp_data = 16'h0001;
      @(negedge clk);
      arm_start = 0; smp_valid = 0;
      expect_trigs("R12 no fire on start cycle", 7);

      cur_req = "R11 random";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 4) start();
         else if (r < 16) begin
            int a;
            a = $urandom_range(0, 15);
            if (a >= 8) wr(a, $urandom_range(0, 2047));
            else if (a == 4) wr(a, $urandom_range(0, 6));
            else wr(a, $urandom_range(0, 15));
         end else smp($urandom_range(0, 15), ($urandom_range(0, 3) != 0),
                      ($urandom_range(0, 2) == 0));
      end
      @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule